// File: doc/BRIEF.md
# Bus Width Adapter with Byte Lane Steering

This block connects a 16-bit host data path to an ISA-style expansion bus. It takes one host access at a time and runs it on the bus. An access is either a full 16-bit word or a single byte. The block places the address, the least significant address bit, a high-lane enable and lane-steered write data on the bus side. A downstream cycle sequencer runs each bus cycle. The block waits for that sequencer to report the end of the cycle, then returns one completion to the host with read data on the lanes the host expects.

Once per access, the block samples a width acknowledge from the bus. It uses the memory acknowledge for memory accesses and the I/O acknowledge for I/O accesses. The acknowledge tells it whether the addressed device is 16 bits wide.

- A word access to a narrow device is split into two 8-bit cycles, low byte first. The high byte travels on the low data lane.
- A byte access is moved between lanes when the lane the host uses differs from the lane the device uses. This covers two cases: an odd byte to an 8-bit device, and an 8-bit DMA channel reaching an odd byte of 16-bit memory.

The host never sees a split or a swap.

Top module: `bus_lane_adapter`

## Requirements
- R1: After reset, req_ready is 1 and rsp_done, cyc_start and rsp_rdata are all 0.
- R2: The width acknowledge is sampled once, in the cycle after acceptance. For memory accesses (req_io=0) it is mem16_ack, and io16_ack is ignored. For I/O accesses it is io16_ack, and mem16_ack is ignored. Later changes to either acknowledge do not alter the access.
- R3: A word access (req_wide=1) with the acknowledge set runs as one bus cycle with cyc_wide=1, bus_addr[0]=0, bus_hi_en=1 and req_wdata unchanged on bus_wdata.
- R4: A word write without the acknowledge runs as two cycles with cyc_wide=0. The first cycle has bus_addr[0]=0, bus_hi_en=0 and bus_wdata={8'h00, req_wdata[7:0]}. The second has bus_addr[0]=1, bus_hi_en=1 and bus_wdata={8'h00, req_wdata[15:8]}.
- R5: A word read without the acknowledge returns rsp_rdata = {bus_rdata[7:0] of the second cycle, bus_rdata[7:0] of the first cycle}. The completion comes only after the second cycle ends.
- R6: A byte access (req_wide=0) at an even address runs one cycle with bus_addr[0]=0 and bus_hi_en=0, and no swap: bus_wdata={8'h00, req_wdata[7:0]}, and rsp_rdata={8'h00, bus_rdata[7:0]}.
- R7: A non-DMA byte access at an odd address to an 8-bit device swaps lanes, with bus_addr[0]=1 and bus_hi_en=1: bus_wdata={8'h00, req_wdata[15:8]}, and rsp_rdata={bus_rdata[7:0], 8'h00}.
- R8: A non-DMA byte access at an odd address to a 16-bit device does not swap: bus_wdata={req_wdata[15:8], 8'h00}, and rsp_rdata={bus_rdata[15:8], 8'h00}.
- R9: A byte access with req_dma8=1 carries its byte on the host's low lane. At an odd address to a 16-bit memory the lanes swap: bus_wdata={req_wdata[7:0], 8'h00} and rsp_rdata={8'h00, bus_rdata[15:8]}. To an 8-bit device there is no swap.
- R10: Each accepted access gives exactly one rsp_done pulse one cycle wide. req_ready stays 0 from acceptance until that pulse.
- R11: bus_addr[ADDR_W-1:1] equals the accepted address and holds steady through every bus cycle of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wide | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_dma8 | input | 1 | Byte transfer from an 8-bit DMA channel (low host lane) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Host write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Reassembled read data, valid with rsp_done |
| bus_addr | output | ADDR_W | Bus address including the LSB per cycle |
| bus_hi_en | output | 1 | High data lane enable (active high) |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Bus read data, taken when cyc_done is high |
| cyc_start | output | 1 | One-cycle pulse starting a bus cycle |
| cyc_write | output | 1 | Direction of the current cycle |
| cyc_io | output | 1 | Space of the current cycle |
| cyc_wide | output | 1 | Current cycle uses 16-bit device timing |
| cyc_done | input | 1 | Sequencer reports the current cycle ended |
| mem16_ack | input | 1 | Memory device is 16 bits wide |
| io16_ack | input | 1 | I/O device is 16 bits wide |

## Verification
Two functions meet in the same clock edge in a split read. The end of the low-byte cycle stores the low byte in the holding register, and the address LSB and high-lane enable switch over for the high-byte cycle.

Split reads provoke this. Each half returns a distinct low-lane byte with unrelated values in the upper lane. The bench then checks the reassembled word, which must contain only the two low-lane bytes in order. It also checks that the second cycle came out with bus_addr[0]=1 and bus_hi_en=1, and that the first byte survived the change of phase.

// File: rtl/bus_lane_adapter.sv
module bus_lane_adapter #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_wide,
  input  logic              req_dma8,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_hi_en,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  output logic              cyc_start,
  output logic              cyc_write,
  output logic              cyc_io,
  output logic              cyc_wide,
  input  logic              cyc_done,
  input  logic              mem16_ack,
  input  logic              io16_ack
);
  localparam int LANE_W = 8;

  typedef enum logic [2:0] {S_IDLE, S_PROBE, S_ISSUE, S_WAIT, S_DONE} state_t;
  state_t state;

  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wd_q, rd_q;
  logic              wr_q, io_q, wide_q, dma8_q, dev16_q, hi_q;

  logic              split, full, cur_a0, host_hi, dev_hi;
  logic [LANE_W-1:0] host_byte, bus_byte;

  assign split     = wide_q & ~dev16_q;
  assign full      = wide_q & dev16_q;
  assign cur_a0    = full ? 1'b0 : (split ? hi_q : addr_q[0]);
  assign host_hi   = split ? hi_q : (~dma8_q & addr_q[0]);
  assign dev_hi    = ~wide_q & dev16_q & addr_q[0];
  assign host_byte = host_hi ? wd_q[15:8] : wd_q[7:0];
  assign bus_byte  = dev_hi ? bus_rdata[15:8] : bus_rdata[7:0];

  assign req_ready = (state == S_IDLE);
  assign rsp_done  = (state == S_DONE);
  assign rsp_rdata = rd_q;
  assign cyc_start = (state == S_ISSUE);
  assign cyc_write = wr_q;
  assign cyc_io    = io_q;
  assign cyc_wide  = dev16_q;
  assign bus_addr  = {addr_q[ADDR_W-1:1], cur_a0};
  assign bus_hi_en = full | cur_a0;
  assign bus_wdata = full   ? wd_q :
                     dev_hi ? {host_byte, {LANE_W{1'b0}}} :
                              {{LANE_W{1'b0}}, host_byte};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      wr_q    <= 1'b0;
      io_q    <= 1'b0;
      wide_q  <= 1'b0;
      dma8_q  <= 1'b0;
      dev16_q <= 1'b0;
      hi_q    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          wr_q   <= req_write;
          io_q   <= req_io;
          wide_q <= req_wide;
          dma8_q <= req_dma8 & ~req_wide;
          hi_q   <= 1'b0;
          rd_q   <= '0;
          state  <= S_PROBE;
        end
        S_PROBE: begin
          dev16_q <= io_q ? io16_ack : mem16_ack;
          state   <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (cyc_done) begin
          if (!wr_q) begin
            if (full)         rd_q <= bus_rdata;
            else if (host_hi) rd_q[15:8] <= bus_byte;
            else              rd_q[7:0]  <= bus_byte;
          end
          if (split && !hi_q) begin
            hi_q  <= 1'b1;
            state <= S_ISSUE;
          end else begin
            state <= S_DONE;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_lane_adapter_chk.sv
module bus_lane_adapter_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              cyc_start,
  input logic              cyc_wide,
  input logic              bus_hi_en,
  input logic [ADDR_W-1:0] bus_addr
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r10_busy_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> !req_ready);

  a_r10_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start);

  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> $stable(bus_addr));

  a_r7_odd_hi_en: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start && bus_addr[0] |-> bus_hi_en);

  a_r4_even_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start && !cyc_wide && !bus_addr[0] |-> !bus_hi_en);
endmodule

bind bus_lane_adapter bus_lane_adapter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .cyc_start(cyc_start), .cyc_wide(cyc_wide), .bus_hi_en(bus_hi_en),
  .bus_addr(bus_addr)
);

// File: tb/bus_lane_adapter_bench.sv
module bus_lane_adapter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_io = 0, req_wide = 0, req_dma8 = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0, bus_rdata = '0;
  logic cyc_done = 0, mem16_ack = 0, io16_ack = 0;
  logic req_ready, rsp_done, bus_hi_en, cyc_start, cyc_write, cyc_io, cyc_wide;
  logic [15:0] rsp_rdata, bus_wdata;
  logic [AW-1:0] bus_addr;

  int n_chk = 0, n_fail = 0;
  int n_cyc, n_done, busy_err, addr_err;
  logic [15:0] got_rd;
  logic        c_a0[2], c_hi[2], c_wide[2];
  logic [15:0] c_wd[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_lane_adapter #(.ADDR_W(AW)) u_bus_lane_adapter (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, io, wide, dma8, input logic [AW-1:0] addr,
                        input logic [15:0] wd, input logic mack, iack,
                        input logic [15:0] rd0, rd1);
    int pend = 0;
    int tail = -1;
    n_cyc = 0; n_done = 0; busy_err = 0; addr_err = 0; got_rd = 'x;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_io = io; req_wide = wide; req_dma8 = dma8;
    req_addr = addr; req_wdata = wd; mem16_ack = mack; io16_ack = iack;
    @(negedge clk);
    req_valid = 0; req_wdata = 16'hxxxx;
    for (int t = 0; t < 60 && tail != 0; t++) begin
      cyc_done = 0;
      if (cyc_start) begin
        if (n_cyc < 2) begin
          c_a0[n_cyc] = bus_addr[0]; c_hi[n_cyc] = bus_hi_en;
          c_wd[n_cyc] = bus_wdata;   c_wide[n_cyc] = cyc_wide;
        end
        if (bus_addr[AW-1:1] !== addr[AW-1:1]) addr_err++;
        n_cyc++;
        mem16_ack = ~mack; io16_ack = ~iack;
        pend = 3;
      end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          cyc_done = 1;
          bus_rdata = (n_cyc == 1) ? rd0 : rd1;
        end
      end
      if (rsp_done) begin
        n_done++; got_rd = rsp_rdata; tail = 4;
      end else if (tail > 0) tail--;
      if (n_done == 0 && req_ready) busy_err++;
      @(negedge clk);
    end
    cyc_done = 0;
    check("R10 done count", n_done, 1);
    check("R10 ready low while busy", busy_err, 0);
    check("R11 upper address held", addr_err, 0);
  endtask

  task automatic t_reset;
    check("R1 req_ready", req_ready, 1);
    check("R1 rsp_done", rsp_done, 0);
    check("R1 cyc_start", cyc_start, 0);
    check("R1 rsp_rdata", rsp_rdata, 0);
  endtask

  task automatic t_wide_16;
    access(1, 0, 1, 0, 24'h001000, 16'h1234, 1, 0, 0, 0);
    check("R3 one cycle", n_cyc, 1);
    check("R3 a0", c_a0[0], 0);
    check("R3 hi_en", c_hi[0], 1);
    check("R3 wide", c_wide[0], 1);
    check("R3 wdata", c_wd[0], 16'h1234);
    access(0, 1, 1, 0, 24'h0A0302, 16'h0, 0, 1, 16'hBEEF, 0);
    check("R3 R2 io read cycles", n_cyc, 1);
    check("R3 read data", got_rd, 16'hBEEF);
  endtask

  task automatic t_split;
    access(1, 0, 1, 0, 24'h123456, 16'h1234, 0, 1, 0, 0);
    check("R4 R2 two cycles", n_cyc, 2);
    check("R4 low a0", c_a0[0], 0);
    check("R4 low hi_en", c_hi[0], 0);
    check("R4 low wdata", c_wd[0], 16'h0034);
    check("R4 high a0", c_a0[1], 1);
    check("R4 high hi_en", c_hi[1], 1);
    check("R4 high wdata", c_wd[1], 16'h0012);
    check("R4 narrow timing", c_wide[0], 0);
    access(0, 1, 1, 0, 24'h000300, 16'h0, 1, 0, 16'h77AB, 16'h66CD);
    check("R5 R2 io split cycles", n_cyc, 2);
    check("R5 second a0", c_a0[1], 1);
    check("R5 second hi_en", c_hi[1], 1);
    check("R5 reassembled", got_rd, 16'hCDAB);
  endtask

  task automatic t_even_byte;
    access(1, 0, 0, 0, 24'h000010, 16'h5A3C, 1, 0, 0, 0);
    check("R6 cycles", n_cyc, 1);
    check("R6 a0", c_a0[0], 0);
    check("R6 hi_en", c_hi[0], 0);
    check("R6 wdata", c_wd[0], 16'h003C);
    access(0, 0, 0, 0, 24'h000010, 16'h0, 0, 0, 16'h99C3, 0);
    check("R6 rdata", got_rd, 16'h00C3);
  endtask

  task automatic t_odd_byte;
    access(1, 0, 0, 0, 24'h000011, 16'h5A3C, 0, 0, 0, 0);
    check("R7 a0", c_a0[0], 1);
    check("R7 hi_en", c_hi[0], 1);
    check("R7 swapped wdata", c_wd[0], 16'h005A);
    access(0, 0, 0, 0, 24'h000011, 16'h0, 0, 0, 16'h1177, 0);
    check("R7 swapped rdata", got_rd, 16'h7700);
    access(1, 0, 0, 0, 24'h000011, 16'h5A3C, 1, 0, 0, 0);
    check("R8 hi_en", c_hi[0], 1);
    check("R8 unswapped wdata", c_wd[0], 16'h5A00);
    access(0, 0, 0, 0, 24'h000011, 16'h0, 1, 0, 16'h4411, 0);
    check("R8 unswapped rdata", got_rd, 16'h4400);
  endtask

  task automatic t_dma8;
    access(1, 0, 0, 1, 24'h000021, 16'h5A3C, 1, 0, 0, 0);
    check("R9 a0", c_a0[0], 1);
    check("R9 swapped wdata", c_wd[0], 16'h3C00);
    access(0, 0, 0, 1, 24'h000021, 16'h0, 1, 0, 16'h4411, 0);
    check("R9 swapped rdata", got_rd, 16'h0044);
    access(1, 0, 0, 1, 24'h000021, 16'h5A3C, 0, 0, 0, 0);
    check("R9 8-bit wdata", c_wd[0], 16'h003C);
    access(0, 0, 0, 1, 24'h000021, 16'h0, 0, 0, 16'h4411, 0);
    check("R9 8-bit rdata", got_rd, 16'h0011);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_wide_16();
    t_split();
    t_even_byte();
    t_odd_byte();
    t_dma8();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule